// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

A first-in first-out buffer of 9-bit words whose depth is set by an address-width parameter (256 words by default, up to 8192). Writing runs on its own clock and reading on another. The two clocks may be one net, or they may be unrelated. Each side is qualified by a pair of enables: one active-low and one active-high. A word moves only when both enables of that side are active. Read data leaves through an output register. An output-enable input either drives that register onto the data pins or releases them. The release is modelled by driving zero and lowering a separate drive-indicator output.

Four status flags report the fill level. Empty and almost-empty are computed in the read domain. Full and almost-full are computed in the write domain. Each pointer crosses to the other domain as Gray code through a two-flop synchroniser. The almost thresholds come from two offset registers. Reset sets both to 7. While the load input is high, qualified write edges store the data input into the offset registers in place of the array. The stores alternate between the two registers, starting with the almost-empty offset. An asynchronous active-low reset clears the pointers, the output register, the offsets and the load sequence.

Top module: `prog_flag_fifo`

## Requirements
- R1: A word is stored on a rising wr_clk edge only when wr_en_n is 0, wr_en is 1, load_off is 0 and full is 0. Any other enable combination stores nothing.
- R2: On a rising rd_clk edge with rd_en_n 0, rd_en 1 and empty 0, the oldest word is loaded into the output register and shown on rd_q after that edge. Words come out in write order. With either read enable inactive, nothing is read.
- R3: A write attempted while full is 1 is dropped. The stored words and their order are kept, and full stays 1.
- R4: A read attempted while empty is 1 is dropped. rd_q keeps its last value, and the next word written is the next word read.
- R5: empty is 1 exactly when the read-domain fill count is 0. full is 1 exactly when the write-domain fill count equals the depth. With both clocks tied, a change on the other side reaches the flag within three edges.
- R6: With the offsets at their reset value of 7, almost_empty is 1 at a fill count of 7 or less. almost_full is 1 at a fill count of depth minus 7 or more.
- R7: While load_off is 1, each qualified write edge stores the low address-width bits of wr_data into an offset register, and the array is not written. The first store goes to the almost-empty offset and the second to the almost-full offset. The third returns to the almost-empty offset.
- R8: With loaded offsets E and F, almost_empty is 1 at a fill count of E or less. almost_full is 1 at a fill count of depth minus F or more.
- R9: With out_en 1, rd_q shows the output register and rd_q_drv is 1. With out_en 0, rd_q is 0 and rd_q_drv is 0.
- R10: While rst_n is 0, the block is emptied, rd_q is cleared to 0, both offsets return to 7 and the load sequence restarts. After reset, empty=1, almost_empty=1, full=0 and almost_full=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_n | input | 1 | Active-low write enable |
| wr_en | input | 1 | Active-high write enable |
| load_off | input | 1 | Steers qualified writes into the offset registers |
| wr_data | input | 9 | Write data, or an offset value while loading |
| rd_en_n | input | 1 | Active-low read enable |
| rd_en | input | 1 | Active-high read enable |
| out_en | input | 1 | Output enable for rd_q |
| rd_q | output | 9 | Registered read data (0 when released) |
| rd_q_drv | output | 1 | 1 while rd_q is driven |
| empty | output | 1 | No words visible to the reader |
| almost_empty | output | 1 | Fill count at or below the almost-empty offset |
| full | output | 1 | Fill count equals the depth |
| almost_full | output | 1 | Fill count at or above depth minus the almost-full offset |

## Verification
The buffer is exercised with single words, with runs that fill it completely and then drain it, and with every partial enable combination. The full-to-drain run shows whether a dropped write at full corrupted the order. The partial-enable cases separate the AND qualification from a single-enable decode. Each threshold is stepped one word below and one word at its boundary, under both the defaults and loaded values. This separates an off-by-one comparison and a swapped offset sequence from a correct one. A load of three values checks that the sequence wraps to the almost-empty offset, and an empty check after loading shows that the array was not written.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic {
    OFS_LOW  = 1'b0,
    OFS_HIGH = 1'b1
  } pff_ofs_sel_e;
endpackage

// File: rtl/pff_ptr_sync.sv
module pff_ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = gray_to_bin(stage2);
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (re) q <= cells[raddr];
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 8,
  parameter int DEF_OFF = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              wr_en,
  input  logic              load_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              rd_en,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_q_drv,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);
  import pff_pkg::*;

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);
  localparam logic [ADDR_W-1:0] OFF_RST = ADDR_W'(DEF_OFF);

  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] fill_count(input logic [CNT_W-1:0] wp,
                                                  input logic [CNT_W-1:0] rp);
    return wp - rp;
  endfunction

  // Named internal events, visible to the bound checker
  logic              wr_req, rd_req, wr_fire, rd_fire, ld_fire;
  logic [CNT_W-1:0]  wr_bin, rd_bin, wr_gray, rd_gray;
  logic [CNT_W-1:0]  wr_bin_rs, rd_bin_ws;
  logic [CNT_W-1:0]  wcount, rcount;
  logic [ADDR_W-1:0] ae_off, af_off;
  logic [DATA_W-1:0] q_reg;
  pff_ofs_sel_e      ld_sel;

  assign wr_req  = !wr_en_n && wr_en;
  assign rd_req  = !rd_en_n && rd_en;
  assign ld_fire = wr_req && load_off;
  assign wr_fire = wr_req && !load_off && !full;
  assign rd_fire = rd_req && !empty;

  // Write pointer
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (wr_fire) begin
      wr_bin  <= wr_bin + 1'b1;
      wr_gray <= bin_to_gray(wr_bin + 1'b1);
    end
  end

  // Offset registers, loaded in alternation
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= OFF_RST;
      af_off <= OFF_RST;
      ld_sel <= OFS_LOW;
    end else if (ld_fire) begin
      if (ld_sel == OFS_LOW) ae_off <= ADDR_W'(wr_data);
      else                   af_off <= ADDR_W'(wr_data);
      ld_sel <= (ld_sel == OFS_LOW) ? OFS_HIGH : OFS_LOW;
    end
  end

  // Read pointer
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (rd_fire) begin
      rd_bin  <= rd_bin + 1'b1;
      rd_gray <= bin_to_gray(rd_bin + 1'b1);
    end
  end

  pff_ptr_sync #(.W(CNT_W)) u_wsync (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_bin_rs));

  pff_ptr_sync #(.W(CNT_W)) u_rsync (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_bin_ws));

  pff_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(wr_fire), .waddr(wr_bin[ADDR_W-1:0]), .wdata(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .re(rd_fire), .raddr(rd_bin[ADDR_W-1:0]),
    .q(q_reg));

  // Flags: write side sees a lagging read pointer and the reverse
  assign wcount       = fill_count(wr_bin, rd_bin_ws);
  assign rcount       = fill_count(wr_bin_rs, rd_bin);
  assign full         = (wcount == DEPTH_C);
  assign almost_full  = (wcount >= (DEPTH_C - {1'b0, af_off}));
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= {1'b0, ae_off});

  assign rd_q     = out_en ? q_reg : '0;
  assign rd_q_drv = out_en;
endmodule

// File: rtl/pff_chk.sv
module pff_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              rd_req,
  input logic              load_off,
  input logic              full,
  input logic              empty,
  input logic              almost_full,
  input logic              almost_empty,
  input logic [ADDR_W:0]   wr_bin,
  input logic [ADDR_W:0]   rd_bin,
  input logic [ADDR_W:0]   wcount,
  input logic [ADDR_W:0]   rcount,
  input logic [DATA_W-1:0] q_reg
);
  localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W + 1)'(1 << ADDR_W);

  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_req && !load_off && full) |=> (wr_bin == $past(wr_bin)));

  a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_req && empty) |=> (rd_bin == $past(rd_bin) && $stable(q_reg)));

  a_r2_read_advance: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_req && !empty) |=> (rd_bin == (ADDR_W + 1)'($past(rd_bin) + 1'b1)));

  a_r7_load_skips_array: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_req && load_off) |=> (wr_bin == $past(wr_bin)));

  a_r5_wcount_bound: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wcount <= DEPTH_C);

  a_r5_rcount_bound: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rcount <= DEPTH_C);

  a_r8_full_implies_af: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> almost_full);

  a_r8_empty_implies_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

bind prog_flag_fifo pff_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_req(wr_req), .rd_req(rd_req), .load_off(load_off),
  .full(full), .empty(empty), .almost_full(almost_full),
  .almost_empty(almost_empty), .wr_bin(wr_bin), .rd_bin(rd_bin),
  .wcount(wcount), .rcount(rcount), .q_reg(q_reg));

// File: tb/prog_flag_fifo_tb_top.sv
`timescale 1ns/1ps
module prog_flag_fifo_tb_top;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en_n = 1'b1, wr_en = 1'b0, load_off = 1'b0;
  logic [8:0] wr_data = '0;
  logic rd_en_n = 1'b1, rd_en = 1'b0, out_en = 1'b1;
  logic [8:0] rd_q;
  logic rd_q_drv, empty, almost_empty, full, almost_full;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  prog_flag_fifo dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_en(wr_en), .load_off(load_off), .wr_data(wr_data),
    .rd_en_n(rd_en_n), .rd_en(rd_en), .out_en(out_en),
    .rd_q(rd_q), .rd_q_drv(rd_q_drv), .empty(empty),
    .almost_empty(almost_empty), .full(full), .almost_full(almost_full));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37) ^ 9'h0A5);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load_off = 1'b0;
    wr_en_n = 1'b1; wr_en = 1'b0; rd_en_n = 1'b1; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input logic [8:0] d, input logic en_n = 1'b0, input logic en = 1'b1);
    @(negedge clk);
    wr_data = d; wr_en_n = en_n; wr_en = en;
    @(negedge clk);
    wr_en_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic pop(output logic [8:0] d, input logic en_n = 1'b0, input logic en = 1'b1);
    @(negedge clk);
    rd_en_n = en_n; rd_en = en;
    @(negedge clk);
    rd_en_n = 1'b1; rd_en = 1'b0;
    d = rd_q;
  endtask

  task automatic fill(input int from, input int to);
    for (int i = from; i < to; i++) push(pat(i));
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 empty", empty, 1);
    chk("R10 almost_empty", almost_empty, 1);
    chk("R10 full", full, 0);
    chk("R10 almost_full", almost_full, 0);
    chk("R10 rd_q cleared", rd_q, 0);
    chk("R9 drv high", rd_q_drv, 1);
  endtask

  task automatic t_enables();
    logic [8:0] d;
    do_reset();
    push(9'h011, 1'b1, 1'b1);
    push(9'h012, 1'b0, 1'b0);
    push(9'h013, 1'b1, 1'b0);
    settle();
    chk("R1 partial write enables store nothing", empty, 1);
    push(9'h1C3);
    settle();
    chk("R1 qualified write clears empty", empty, 0);
    pop(d, 1'b1, 1'b1);
    chk("R2 rd_en_n high no read", d, 0);
    pop(d, 1'b0, 1'b0);
    chk("R2 rd_en low no read", d, 0);
    chk("R2 word still held", empty, 0);
    pop(d);
    chk("R2 read data", d, 9'h1C3);
    chk("R5 empty after last read", empty, 1);
    out_en = 1'b0;
    #1;
    chk("R9 released rd_q", rd_q, 0);
    chk("R9 released drv", rd_q_drv, 0);
    out_en = 1'b1;
    #1;
    chk("R9 driven rd_q", rd_q, 9'h1C3);
    pop(d);
    chk("R4 read at empty keeps rd_q", d, 9'h1C3);
    push(9'h0F0);
    settle();
    pop(d);
    chk("R4 next word after empty read", d, 9'h0F0);
  endtask

  task automatic t_default_flags();
    logic [8:0] d;
    int bad_order = 0;
    do_reset();
    fill(0, 7);
    settle();
    chk("R6 ae at 7", almost_empty, 1);
    fill(7, 8);
    settle();
    chk("R6 ae off at 8", almost_empty, 0);
    fill(8, DEPTH - 8);
    settle();
    chk("R6 af off at depth-8", almost_full, 0);
    fill(DEPTH - 8, DEPTH - 7);
    settle();
    chk("R6 af at depth-7", almost_full, 1);
    chk("R5 not full at depth-7", full, 0);
    fill(DEPTH - 7, DEPTH);
    chk("R5 full at depth", full, 1);
    push(9'h1FF);
    push(9'h000);
    chk("R3 full held after dropped writes", full, 1);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      if (d != pat(i)) bad_order++;
    end
    chk("R3 drained words in order", bad_order, 0);
    settle();
    chk("R5 empty after drain", empty, 1);
    chk("R5 full cleared after drain", full, 0);
  endtask

  task automatic t_load();
    do_reset();
    load_off = 1'b1;
    push(9'd3);
    push(9'd20);
    load_off = 1'b0;
    settle();
    chk("R7 load does not fill array", empty, 1);
    fill(0, 3);
    settle();
    chk("R8 ae at loaded 3", almost_empty, 1);
    fill(3, 4);
    settle();
    chk("R8 ae off at 4", almost_empty, 0);
    fill(4, DEPTH - 21);
    settle();
    chk("R8 af off at depth-21", almost_full, 0);
    fill(DEPTH - 21, DEPTH - 20);
    settle();
    chk("R8 af at depth-20", almost_full, 1);
    do_reset();
    fill(0, DEPTH - 7);
    settle();
    chk("R10 offsets back to 7 af", almost_full, 1);
    do_reset();
    load_off = 1'b1;
    push(9'd5);
    push(9'd30);
    push(9'd2);
    load_off = 1'b0;
    fill(0, 2);
    settle();
    chk("R7 wrap to ae offset ae at 2", almost_empty, 1);
    fill(2, 3);
    settle();
    chk("R7 wrap ae off at 3", almost_empty, 0);
    fill(3, DEPTH - 31);
    settle();
    chk("R7 af offset 30 off at depth-31", almost_full, 0);
    fill(DEPTH - 31, DEPTH - 30);
    settle();
    chk("R7 af offset 30 on at depth-30", almost_full, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_enables();
    t_default_flags();
    t_load();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule